// File: doc/BRIEF.md
# ADC Multi-Channel Scan Sequencer

This controller drives an external successive-approximation converter across up to eight analog inputs. An 8-bit channel mask chooses which inputs take part. Once started, the block visits the enabled channels in rising order and passes over disabled ones. For each conversion it presents a channel number and pulses a start request. When the converter signals done, the block stores the 12-bit result in that channel's own result register.

In single-pass mode the block walks the enabled channels once. It then raises a sticky completion flag, drops its own start bit and goes idle. In continuous mode it returns to the lowest enabled channel after each pass. It keeps scanning while the start bit stays set. The start bit can be set by a software strobe or by an external trigger pulse. Clearing the start bit lets the conversion already in flight complete, and then the block halts. An interrupt output follows the completion flag whenever interrupts are enabled.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the start bit, completion flag, interrupt, conversion request and all eight valid flags are 0.
- R2: A one-cycle pulse on `startSet` or on `trigIn` sets the start bit. The first conversion request that follows names the lowest-numbered enabled channel.
- R3: Conversions are requested one channel at a time in ascending channel order, and channels whose mask bit is 0 are skipped. With mask 8'b1000_1101 the channel select sequence is 0, 2, 3, 7.
- R4: On `convDone` the value on `convData` is stored in the result register of the channel being converted. Result register i occupies `resultFlat[12*i +: 12]`, and bit i of `validVec` is set.
- R5: The completion flag `passDone` is set only when the last enabled channel of a pass completes. It stays set until a `doneClr` pulse clears it.
- R6: `irq` is 1 exactly when `passDone` is 1 and `irqEn` is 1.
- R7: In continuous mode (`modeCont`=1) the block restarts at the lowest enabled channel after each pass. It keeps repeating the same sequence while the start bit is 1.
- R8: A `startClr` pulse during a scan lets the in-flight conversion finish and store its result. After that no further conversion is requested.
- R9: In single-pass mode (`modeCont`=0) the start bit returns to 0 by itself after one complete pass, and no further conversion is requested.
- R10: A pulse on bit i of `rdStrobe` clears bit i of `validVec`.
- R11: When the start bit is set while the mask is all zero, no conversion is requested and `passDone` stays 0.
- R12: `convStart` is a one-cycle pulse. It is not repeated until the converter has answered, and `convSel` holds steady while a conversion is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSet | input | 1 | Software strobe that sets the start bit |
| trigIn | input | 1 | External trigger pulse that sets the start bit |
| startClr | input | 1 | Software strobe that clears the start bit |
| modeCont | input | 1 | 1 = continuous scan, 0 = single pass |
| irqEn | input | 1 | Interrupt enable |
| chanMask | input | 8 | Channel enable mask, bit i enables channel i |
| doneClr | input | 1 | Write-one-to-clear strobe for the completion flag |
| rdStrobe | input | 8 | Per-channel read strobe, clears that channel's valid flag |
| convStart | output | 1 | Start-conversion pulse to the converter |
| convSel | output | 3 | Channel number for the converter |
| convDone | input | 1 | Conversion-finished strobe from the converter |
| convData | input | 12 | Conversion result from the converter |
| resultFlat | output | 96 | Eight 12-bit result registers, channel i at bits 12*i+11:12*i |
| validVec | output | 8 | Per-channel result valid flags |
| startBit | output | 1 | Current value of the start bit |
| passDone | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong channel pointer shows on `convSel` at the very next `convStart`. A missed skip or a wrong order therefore shows within one conversion. A result written to the wrong register shows in `resultFlat` and `validVec` one cycle after `convDone`. A mistake in pass-end detection shows at the end of the first pass: `passDone` rises early or not at all, or the start bit is not dropped in single-pass mode. A stop that is handled wrongly shows as an extra `convStart` within a few cycles of the in-flight conversion's done strobe.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int NUM_CH = 8;
  localparam int CH_W   = $clog2(NUM_CH);

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic            wrEn;      // store convData into result[wrCh]
    logic [CH_W-1:0] wrCh;
    logic            setDone;   // a full pass has completed
    logic            clrStart;  // single pass over, drop start bit
  } seqStrb_t;

  // {hit, index} of the lowest set bit
  function automatic logic [CH_W:0] lowestSet(input logic [NUM_CH-1:0] m);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) r = {1'b1, CH_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBit,
  input  logic              modeCont,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              convDone,
  output logic              convStart,
  output logic [CH_W-1:0]   convSel,
  output seqStrb_t          strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_t;

  state_t          state, stateNxt;
  logic [CH_W-1:0] curCh, curChNxt;
  logic [CH_W:0]   firstEnc, nextEnc;
  logic [NUM_CH-1:0] aboveMask;

  assign aboveMask = chanMask & ~((NUM_CH'(2) << curCh) - NUM_CH'(1));
  assign firstEnc  = lowestSet(chanMask);
  assign nextEnc   = lowestSet(aboveMask);

  assign convStart = (state == ST_ISSUE);
  assign convSel   = curCh;

  always_comb begin
    stateNxt = state;
    curChNxt = curCh;
    strb     = '0;
    strb.wrCh = curCh;
    case (state)
      ST_IDLE: begin
        if (startBit && firstEnc[CH_W]) begin
          curChNxt = firstEnc[CH_W-1:0];
          stateNxt = ST_ISSUE;
        end
      end
      ST_ISSUE: stateNxt = ST_WAIT;
      ST_WAIT: begin
        if (convDone) begin
          strb.wrEn = 1'b1;
          if (nextEnc[CH_W]) begin
            if (startBit) begin
              curChNxt = nextEnc[CH_W-1:0];
              stateNxt = ST_ISSUE;
            end else begin
              stateNxt = ST_IDLE;
            end
          end else begin
            strb.setDone = 1'b1;
            if (!modeCont) begin
              strb.clrStart = 1'b1;
              stateNxt      = ST_IDLE;
            end else if (startBit && firstEnc[CH_W]) begin
              curChNxt = firstEnc[CH_W-1:0];
              stateNxt = ST_ISSUE;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curCh <= '0;
    end else begin
      state <= stateNxt;
      curCh <= curChNxt;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R12
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && $past(state) != ST_IDLE) |-> $stable(convSel)); // R12
  AST_ZERO_MASK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (chanMask == '0 && state == ST_IDLE) |=> !convStart); // R11
  AST_DONE_NEEDS_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |-> convDone); // R5
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startSet,
  input  logic                     trigIn,
  input  logic                     startClr,
  input  logic                     doneClr,
  input  logic [NUM_CH-1:0]        rdStrobe,
  input  logic [DATA_W-1:0]        convData,
  input  seqStrb_t                 strb,
  output logic                     startBit,
  output logic                     passDone,
  output logic [NUM_CH*DATA_W-1:0] resultFlat,
  output logic [NUM_CH-1:0]        validVec
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit <= 1'b0;
      passDone <= 1'b0;
    end else begin
      if (startSet || trigIn)             startBit <= 1'b1;
      else if (startClr || strb.clrStart) startBit <= 1'b0;
      if (strb.setDone)  passDone <= 1'b1;
      else if (doneClr)  passDone <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = strb.wrEn && (strb.wrCh == CH_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resultFlat[g*DATA_W +: DATA_W] <= '0;
        validVec[g]                    <= 1'b0;
      end else begin
        if (hit) resultFlat[g*DATA_W +: DATA_W] <= convData;
        if (hit)              validVec[g] <= 1'b1;
        else if (rdStrobe[g]) validVec[g] <= 1'b0;
      end
    end
  end

  AST_VALID_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> validVec[$past(strb.wrCh)]); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (passDone && !doneClr) |=> passDone); // R5
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStart && !startSet && !trigIn) |=> !startBit); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe[0] && !(strb.wrEn && strb.wrCh == '0)) |=> !validVec[0]); // R10
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startSet,
  input  logic                     trigIn,
  input  logic                     startClr,
  input  logic                     modeCont,
  input  logic                     irqEn,
  input  logic [NUM_CH-1:0]        chanMask,
  input  logic                     doneClr,
  input  logic [NUM_CH-1:0]        rdStrobe,
  output logic                     convStart,
  output logic [CH_W-1:0]          convSel,
  input  logic                     convDone,
  input  logic [DATA_W-1:0]        convData,
  output logic [NUM_CH*DATA_W-1:0] resultFlat,
  output logic [NUM_CH-1:0]        validVec,
  output logic                     startBit,
  output logic                     passDone,
  output logic                     irq
);
  seqStrb_t strb;

  adc_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startBit(startBit), .modeCont(modeCont),
    .chanMask(chanMask), .convDone(convDone), .convStart(convStart),
    .convSel(convSel), .strb(strb)
  );

  adc_scan_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .startSet(startSet), .trigIn(trigIn),
    .startClr(startClr), .doneClr(doneClr), .rdStrobe(rdStrobe),
    .convData(convData), .strb(strb), .startBit(startBit),
    .passDone(passDone), .resultFlat(resultFlat), .validVec(validVec)
  );

  assign irq = passDone & irqEn; // R6
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rstN = 1'b0;
  logic startSet = 0, trigIn = 0, startClr = 0, modeCont = 0, irqEn = 0, doneClr = 0;
  logic [7:0] chanMask = '0, rdStrobe = '0;
  logic convStart, convDone = 0;
  logic [2:0] convSel;
  logic [DW-1:0] convData = '0;
  logic [8*DW-1:0] resultFlat;
  logic [7:0] validVec;
  logic startBit, passDone, irq;

  int checks = 0, errors = 0, cycles = 0;
  int logCnt = 0;
  logic [2:0] logSel [0:1023];
  logic [DW-1:0] lastData [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rstN(rstN), .startSet(startSet), .trigIn(trigIn),
    .startClr(startClr), .modeCont(modeCont), .irqEn(irqEn),
    .chanMask(chanMask), .doneClr(doneClr), .rdStrobe(rdStrobe),
    .convStart(convStart), .convSel(convSel), .convDone(convDone),
    .convData(convData), .resultFlat(resultFlat), .validVec(validVec),
    .startBit(startBit), .passDone(passDone), .irq(irq)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int popCnt(input logic [7:0] m);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(m[i]);
    return n;
  endfunction

  // expected k-th channel (k counted from 0) of a repeating scan over mask m
  function automatic int expCh(input logic [7:0] m, input int k);
    int n = popCnt(m);
    int idx = k % n;
    for (int i = 0; i < 8; i++) begin
      if (m[i]) begin
        if (idx == 0) return i;
        idx--;
      end
    end
    return -1;
  endfunction

  // behavioural converter
  initial begin
    forever begin
      @(posedge clk);
      if (convStart === 1'b1) begin
        logic [2:0] s;
        logic [DW-1:0] d;
        int lat;
        s = convSel;
        logSel[logCnt % 1024] = s;
        logCnt++;
        lat = 1 + int'($urandom % 4);
        d = DW'($urandom);
        repeat (lat) @(posedge clk);
        @(negedge clk);
        convDone = 1'b1;
        convData = d;
        lastData[s] = d;
        @(negedge clk);
        convDone = 1'b0;
      end
    end
  end

  task automatic pulseClear();
    @(negedge clk);
    doneClr = 1; rdStrobe = 8'hFF;
    @(negedge clk);
    doneClr = 0; rdStrobe = 8'h00;
  endtask

  task automatic waitIdle(output logic ok);
    int t = 0;
    ok = 1;
    while (startBit !== 1'b0) begin
      @(negedge clk);
      t++;
      if (t > 3000) begin ok = 0; break; end
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic singlePass(input logic [7:0] m, input logic useTrig, input logic ie);
    logic ok;
    pulseClear();
    chanMask = m; modeCont = 0; irqEn = ie; logCnt = 0;
    @(negedge clk);
    if (useTrig) trigIn = 1; else startSet = 1;
    @(negedge clk);
    trigIn = 0; startSet = 0;
    waitIdle(ok);
    check(ok, "R9 start bit self-clears", int'(startBit), 0);
    check(logCnt == popCnt(m), "R3 conversion count", logCnt, popCnt(m));
    for (int k = 0; k < logCnt && k < 8; k++)
      check(int'(logSel[k]) == expCh(m, k), "R3 R2 channel order", int'(logSel[k]), expCh(m, k));
    for (int i = 0; i < 8; i++)
      if (m[i]) check(resultFlat[i*DW +: DW] == lastData[i], "R4 result stored",
                      int'(resultFlat[i*DW +: DW]), int'(lastData[i]));
    check(validVec == m, "R4 valid flags", int'(validVec), int'(m));
    check(passDone === 1'b1, "R5 pass flag set", int'(passDone), 1);
    check(irq === ie, "R6 irq follows enable", int'(irq), int'(ie));
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(startBit === 0 && passDone === 0 && irq === 0, "R1 flags at reset",
          int'({startBit, passDone, irq}), 0);
    check(validVec === 8'h00 && convStart === 0, "R1 valid/convStart at reset",
          int'({convStart, validVec}), 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // directed: mask 8'b1000_1101 gives 0,2,3,7
    singlePass(8'b1000_1101, 1'b0, 1'b1);
    check(logSel[0] == 0 && logSel[1] == 2 && logSel[2] == 3 && logSel[3] == 7,
          "R3 directed sequence", int'({logSel[0], logSel[1], logSel[2], logSel[3]}), 'o0237);
    // R5 sticky, R10 read clears valid
    repeat (5) @(negedge clk);
    check(passDone === 1, "R5 flag sticky", int'(passDone), 1);
    rdStrobe = 8'h04;
    @(negedge clk);
    rdStrobe = 8'h00;
    check(validVec == 8'b1000_1001, "R10 read clears valid", int'(validVec), 'h89);
    doneClr = 1;
    @(negedge clk);
    doneClr = 0;
    check(passDone === 0 && irq === 0, "R5 R6 write-one clear", int'({passDone, irq}), 0);

    // R11 zero mask
    chanMask = 8'h00; logCnt = 0;
    startSet = 1;
    @(negedge clk);
    startSet = 0;
    repeat (40) @(negedge clk);
    check(logCnt == 0, "R11 no conversion on empty mask", logCnt, 0);
    check(passDone === 0, "R11 no flag on empty mask", int'(passDone), 0);
    startClr = 1;
    @(negedge clk);
    startClr = 0;

    // single channel and full mask corners, then random
    singlePass(8'h80, 1'b1, 1'b0);
    singlePass(8'hFF, 1'b0, 1'b1);
    singlePass(8'h01, 1'b1, 1'b1);
    for (int it = 0; it < 20; it++) begin
      logic [7:0] m;
      m = 8'($urandom);
      if (m == 0) m = 8'h10;
      singlePass(m, 1'($urandom), 1'($urandom));
    end

    // continuous mode with stop mid-pass
    for (int it = 0; it < 4; it++) begin
      logic [7:0] m;
      int n, tgt, t, lastIdx;
      logic ok;
      m = (it == 0) ? 8'b1000_1101 : 8'($urandom);
      if (m == 0) m = 8'h21;
      n = popCnt(m);
      tgt = 2 * n + 1;
      pulseClear();
      chanMask = m; modeCont = 1; irqEn = 1; logCnt = 0;
      @(negedge clk);
      startSet = 1;
      @(negedge clk);
      startSet = 0;
      t = 0;
      while (logCnt < tgt && t < 3000) begin @(negedge clk); t++; end
      startClr = 1;
      @(negedge clk);
      startClr = 0;
      waitIdle(ok);
      repeat (30) @(negedge clk);
      check(logCnt == tgt, "R8 in-flight finishes, no more issued", logCnt, tgt);
      for (int k = 0; k < logCnt && k < 64; k++)
        check(int'(logSel[k]) == expCh(m, k), "R7 repeating order", int'(logSel[k]), expCh(m, k));
      lastIdx = expCh(m, tgt - 1);
      check(resultFlat[lastIdx*DW +: DW] == lastData[lastIdx], "R8 last result stored",
            int'(resultFlat[lastIdx*DW +: DW]), int'(lastData[lastIdx]));
      check(passDone === 1 && irq === 1, "R5 R6 flag in continuous mode", int'({passDone, irq}), 3);
      check(convStart === 0 && startBit === 0, "R12 idle after stop", int'({convStart, startBit}), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule